// File: doc/BRIEF.md
# Pruned CIC Decimator

This block lowers the sample rate of a signed two's complement stream by a fixed factor through six cascaded integrators, a keep-one-in-R downsampler and six comb sections whose differencing looks two decimated samples back. No multiplier is involved; the low-pass shaping comes entirely from adders and subtractors.

Register widths shrink from stage to stage. The first integrator carries the input width plus the whole bit growth of the filter, which is 44 bits. Each later stage keeps only the upper bits of its predecessor, discarding LSBs by an arithmetic right shift. The last comb holds 34 bits and the port presents its upper 32. The source feeds one sample per cycle at most, marking each with a valid strobe. The output emits a valid pulse for every R-th accepted sample.

Top module: `cic_prune_decim`

## Requirements
- R1: The DC gain from input to the internal full-growth scale is (R·D)^S = 4096, and the output equals that full-precision result divided by 4096 to within 16 output LSBs. A held DC input settles to that same value at the output.
- R2: The stage widths are 44, 42, 41, 40, 39 and 38 bits for integrators 1 to 6, and 38, 37, 37, 36, 35 and 34 bits for combs 1 to 6. Each stage takes its predecessor arithmetically shifted right by the width difference. The output is the last comb value shifted right by 2. The output sequence is bit-exact to this arithmetic.
- R3: Integrators wrap modulo their width and never saturate, and full-scale inputs of either sign still give correct outputs.
- R4: The downsampler keeps accepted samples 0, 2, 4 and so on, counting from the first valid input after reset. After N inputs and drain, exactly ceil(N/2) outputs have appeared, and never more than that at any time.
- R5: Each comb outputs its input minus the input it saw two decimated samples earlier. Its delay line advances only on decimated samples, which gives the impulse response of (1+z^-1+z^-2+z^-3)^6 taken at even taps.
- R6: out_valid is a single-cycle pulse per decimated sample and is never high on two consecutive cycles.
- R7: A synchronous reset clears all integrators, comb delay lines, pipeline valids and the decimation phase. out_valid is low during reset and on the cycle after it, and zero input after reset yields zero output.
- R8: Cycles with in_valid low have no effect on any result. out_data holds its value on every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W (32) | Signed input sample |
| out_valid | output | 1 | Decimated sample strobe |
| out_data | output | OUT_W (32) | Signed decimated sample |

## Verification
The bench builds the block with its default values: R = 2, D = 2, six stages and the listed widths. With these values a 32-bit full-scale input wraps the 44-bit first integrator within a few thousand samples, so the long random run exercises wraparound. An odd input count makes the keep-first phase of the two-sample groups visible in the output total. Every output is compared twice. One comparison is bit-exact against a sequential model of the pruned arithmetic. The other is against an unpruned 64-bit model, within a tolerance derived from the worst-case truncation error of each dropped LSB.

// File: rtl/cic_prune_decim.sv
module cic_prune_decim #(
  parameter int IN_W = 32,
  parameter int OUT_W = 32,
  parameter int NSTG = 6,
  parameter int R = 2,
  parameter int D = 2,
  parameter int IW [NSTG] = '{44, 42, 41, 40, 39, 38},
  parameter int CW [NSTG] = '{38, 37, 37, 36, 35, 34}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int PW = (R > 1) ? $clog2(R) : 1;

  logic [NSTG-1:0] iv_q, cv_q;
  logic [PW-1:0]   phase;
  logic            dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      iv_q  <= '0;
      cv_q  <= '0;
      phase <= '0;
    end else begin
      iv_q <= {iv_q[NSTG-2:0], in_valid};
      cv_q <= {cv_q[NSTG-2:0], dec};
      if (iv_q[NSTG-1])
        phase <= (phase == PW'(R-1)) ? '0 : phase + 1'b1;
    end
  end

  assign dec = iv_q[NSTG-1] && (phase == '0);

  for (genvar k = 0; k < NSTG; k++) begin : g_int
    localparam int W = IW[k];
    logic signed [W-1:0] acc, add;
    logic en;
    if (k == 0) begin : g_src
      assign en  = in_valid;
      assign add = W'(in_data);
    end else begin : g_src
      localparam int SH = IW[k-1] - IW[k];
      assign en  = iv_q[k-1];
      assign add = W'(g_int[k-1].acc >>> SH);
    end
    always_ff @(posedge clk) begin
      if (rst)     acc <= '0;
      else if (en) acc <= acc + add;
    end
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_cmb
    localparam int W = CW[k];
    logic signed [W-1:0] x, q;
    logic signed [W-1:0] dl [D];
    logic en;
    if (k == 0) begin : g_src
      localparam int SH = IW[NSTG-1] - CW[0];
      assign en = dec;
      assign x  = W'(g_int[NSTG-1].acc >>> SH);
    end else begin : g_src
      localparam int SH = CW[k-1] - CW[k];
      assign en = cv_q[k-1];
      assign x  = W'(g_cmb[k-1].q >>> SH);
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
        for (int j = 0; j < D; j++) dl[j] <= '0;
      end else if (en) begin
        q     <= x - dl[D-1];
        dl[0] <= x;
        for (int j = 1; j < D; j++) dl[j] <= dl[j-1];
      end
    end
  end

  assign out_valid = cv_q[NSTG-1];
  assign out_data  = OUT_W'(g_cmb[NSTG-1].q >>> (CW[NSTG-1] - OUT_W));
endmodule

// File: rtl/cic_prune_decim_chk.sv
module cic_prune_decim_chk #(
  parameter int R = 2,
  parameter int OUT_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);
  longint n_in, n_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_in  <= 0;
      n_out <= 0;
    end else begin
      if (in_valid)  n_in  <= n_in + 1;
      if (out_valid) n_out <= n_out + 1;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r7_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r8_data_holds: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_data));

  a_r4_output_count: assert property (@(posedge clk) disable iff (rst)
    (n_out * R) <= (n_in + R - 1));
endmodule

bind cic_prune_decim cic_prune_decim_chk #(.R(R), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/cic_prune_decim_tb.sv
module cic_prune_decim_tb;
  localparam int CLK_NS = 10;
  localparam int IWB [6] = '{44, 42, 41, 40, 39, 38};
  localparam int CWB [6] = '{38, 37, 37, 36, 35, 34};
  localparam longint TOL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [31:0] in_data = '0;
  logic out_valid;
  logic signed [31:0] out_data;

  cic_prune_decim u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string tag = "R7";
  longint bi [6], fi [6];
  longint bd [6][2], fd [6][2];
  int phase, n_in, n_out;
  longint q_exact [$], q_full [$];
  longint last_out;
  bit prev_ov = 1'b0;

  function automatic longint wr(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int k = 0; k < 6; k++) begin
      bi[k] = 0; fi[k] = 0;
      bd[k][0] = 0; bd[k][1] = 0; fd[k][0] = 0; fd[k][1] = 0;
    end
    phase = 0; n_in = 0; n_out = 0;
    q_exact.delete(); q_full.delete();
  endfunction

  function automatic void model_step(longint x);
    longint c, f, xv, y;
    n_in++;
    bi[0] = wr(bi[0] + x, IWB[0]);
    fi[0] = fi[0] + x;
    for (int k = 1; k < 6; k++) begin
      bi[k] = wr(bi[k] + (bi[k-1] >>> (IWB[k-1] - IWB[k])), IWB[k]);
      fi[k] = fi[k] + fi[k-1];
    end
    if (phase == 0) begin
      c = bi[5] >>> (IWB[5] - CWB[0]);
      f = fi[5];
      for (int k = 0; k < 6; k++) begin
        xv = (k == 0) ? c : (c >>> (CWB[k-1] - CWB[k]));
        c = wr(xv - bd[k][1], CWB[k]);
        bd[k][1] = bd[k][0]; bd[k][0] = xv;
        y = f - fd[k][1];
        fd[k][1] = fd[k][0]; fd[k][0] = f;
        f = y;
      end
      q_exact.push_back(wr(c >>> (CWB[5] - 32), 32));
      q_full.push_back(f >>> 12);
    end
    phase = (phase + 1) % 2;
  endfunction

  task automatic push(longint x, int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[31:0];
    model_step(x);
    if (gap > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (30) @(negedge clk);
    check(q_exact.size() == 0, "R4 pending outputs", q_exact.size(), 0);
    check(n_out == (n_in + 1) / 2, "R4 output count", n_out, (n_in + 1) / 2);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!out_valid, "R7 valid in reset", out_valid, 0);
    end
    model_reset();
    rst = 1'b0;
  endtask

  always @(negedge clk) begin
    if (out_valid) begin
      check(!prev_ov, "R6 consecutive valid", prev_ov, 0);
      n_out++;
      last_out = out_data;
      if (q_exact.size() == 0) begin
        check(1'b0, "R4 unexpected output", out_data, 0);
      end else begin
        longint e, fe, d;
        e  = q_exact.pop_front();
        fe = q_full.pop_front();
        check(longint'(out_data) == e, {"R2 ", tag}, out_data, e);
        d = longint'(out_data) - fe;
        check(d >= -TOL && d <= TOL, "R1 full-precision bound", out_data, fe);
      end
    end
    prev_ov = out_valid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    check(!out_valid, "R7 reset valid", out_valid, 0);
    check(out_data == 0, "R7 reset data", out_data, 0);
    rst = 1'b0;

    tag = "R5 impulse";
    push(64'sd4194304, 0);
    for (int i = 0; i < 30; i++) push(0, 0);
    drain();

    tag = "R4 odd count phase";
    reset_dut();
    for (int i = 0; i < 7; i++) push(longint'($signed($urandom())), $urandom % 3);
    drain();

    tag = "R3 dc max";
    reset_dut();
    for (int i = 0; i < 60; i++) push(64'sd2147483647, 0);
    drain();
    check(2147483647 - last_out >= 0 && 2147483647 - last_out <= TOL,
          "R1 dc max settle", last_out, 2147483647);

    tag = "R3 dc min";
    reset_dut();
    for (int i = 0; i < 60; i++) push(-64'sd2147483584, 1);
    drain();
    check(-2147483584 - last_out >= 0 && -2147483584 - last_out <= TOL,
          "R1 dc min settle", last_out, -2147483584);

    tag = "R3 R8 random gaps";
    reset_dut();
    for (int i = 0; i < 1500; i++)
      push(longint'($signed($urandom())), ($urandom % 4 == 0) ? int'($urandom % 3) : 0);
    drain();

    tag = "R7 mid-run reset";
    reset_dut();
    for (int i = 0; i < 25; i++) push(longint'($signed($urandom())), 0);
    reset_dut();
    tag = "R7 zeros after reset";
    for (int i = 0; i < 20; i++) push(0, $urandom % 2);
    drain();
    check(last_out == 0, "R7 zero output after reset", last_out, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule